// File: doc/BRIEF.md
# Bitmap-Vectorised Register Add Unit

This unit runs an integer add in which each of the three register fields (destination, first source, second source) names a bitmap control register rather than a single architectural register. The destination field's bitmap sets both the vector length and the registers that are written. Each source field's bitmap supplies the registers that are read. A source sequence that is shorter than the destination sequence wraps around and repeats in ascending register order. Each element is one addition into an internal 32-entry by 32-bit register file, and one element completes per clock.

Every element reads its sources from a copy of the register file taken when the instruction starts. A register written by an earlier element therefore still supplies its old value to the elements that follow it. The bitmap bank accepts any value written to it and reads back the value it holds. The bank comes out of reset with each bitmap holding only its own register, so the unit behaves as a scalar adder. Bitmap 0 is fixed to the set containing only register x0.

A small debug port writes and reads the register file so that operands can be loaded and results inspected. Software loads the bitmaps, loads the operands, pulses `start` with the three fields, and waits for `done`. The `err` flag reports an instruction that named an empty bitmap.

Top module: `bvadd_unit`

## Requirements
- R1: After reset every bitmap n reads back as 1<<n (bit n set, all other bits clear), and `busy`, `done` and `err` are low.
- R2: A write to bitmap 0 is ignored, so it always reads back 1 (register x0 only). A write to any other bitmap stores all 32 bits, and `map_rdata` returns the held value in the same cycle that `map_addr` selects it.
- R3: Register x0 always reads zero. A debug write while the unit is idle updates the addressed register. A debug write while `busy` is high is ignored.
- R4: An accepted `start` performs exactly popcount(bitmap[rd field]) element additions, one per cycle. `busy` rises in the cycle after `start`. `done` is a one-cycle pulse that is high VL+1 cycles after the `start` cycle, where VL is the element count.
- R5: Element i writes the i-th set bit of the destination bitmap, counting from bit 0 upward. Each source uses the i-th set bit of its own bitmap and wraps periodically from its highest set bit back to its lowest.
- R6: All elements read their sources with the values held at the `start` cycle, even when an earlier element of the same instruction has written that register.
- R7: If any of the three selected bitmaps is zero, no register is written, and `done` and `err` are both high one cycle after `start`. `err` is never high without `done`.
- R8: The bitmaps are captured at the `start` cycle. A bitmap write in the same cycle as `start`, or while `busy` is high, does not change the running instruction. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Bitmap write strobe |
| map_addr | input | 5 | Bitmap index for write and read |
| map_wdata | input | 32 | Bitmap write value |
| map_rdata | output | 32 | Held value of the selected bitmap |
| start | input | 1 | Begin an add instruction (taken only when idle) |
| fld_rd | input | 5 | Destination bitmap index |
| fld_rs1 | input | 5 | First source bitmap index |
| fld_rs2 | input | 5 | Second source bitmap index |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was due to an empty bitmap |
| dbg_we | input | 1 | Register-file debug write strobe (idle only) |
| dbg_addr | input | 5 | Register-file debug address |
| dbg_wdata | input | 32 | Register-file debug write value |
| dbg_rdata | output | 32 | Register-file debug read value |

## Verification
The two functions that can fall in the same cycle are a bitmap write and the start of an instruction that uses that same bitmap. A register debug write arriving while elements are still being written is a second such collision. The bench provokes the first by raising `start` together with a write that shrinks the destination bitmap. It provokes the second by issuing a debug write and a second `start` during the run. The result is judged by comparing the whole register file with a model that applies the old bitmap, ignores the late writes, and only afterwards reads back the new bitmap value.

// File: rtl/bvadd_pkg.sv
package bvadd_pkg;

    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int IW   = $clog2(NREG);
    localparam int CW   = $clog2(NREG + 1);

    typedef logic [NREG-1:0] map_t;
    typedef logic [IW-1:0]   idx_t;
    typedef logic [XLEN-1:0] word_t;
    typedef logic [CW-1:0]   cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_t;

    typedef struct packed {
        idx_t rd;
        idx_t rs1;
        idx_t rs2;
    } fields_t;

    typedef struct packed {
        logic  en;
        idx_t  addr;
        word_t data;
    } rf_wr_t;

    function automatic cnt_t popcnt(map_t m);
        cnt_t c;
        c = '0;
        for (int k = 0; k < NREG; k++) begin
            c = c + cnt_t'(m[k]);
        end
        return c;
    endfunction

    // first set bit at or above off, wrapping to the bottom
    function automatic idx_t next_set(map_t m, idx_t off);
        idx_t r;
        idx_t j;
        logic hit;
        r   = off;
        hit = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            j = idx_t'((int'(off) + k) % NREG);
            if (!hit && m[j]) begin
                r   = j;
                hit = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic idx_t idx_inc(idx_t i);
        return (i == idx_t'(NREG - 1)) ? '0 : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/bvadd_maps.sv
module bvadd_maps
    import bvadd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  idx_t    addr,
    input  map_t    wdata,
    output map_t    rdata,
    input  fields_t fld,
    output map_t    map_rd,
    output map_t    map_rs1,
    output map_t    map_rs2
);

    map_t [NREG-1:0] maps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NREG; n++) begin
                maps_q[n] <= map_t'(1) << n;
            end
        end else if (we && addr != '0) begin
            maps_q[addr] <= wdata;
        end
    end

    assign rdata   = maps_q[addr];
    assign map_rd  = maps_q[fld.rd];
    assign map_rs1 = maps_q[fld.rs1];
    assign map_rs2 = maps_q[fld.rs2];

endmodule

// File: rtl/bvadd_iter.sv
module bvadd_iter
    import bvadd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic adv,
    input  map_t map_in,
    output idx_t sel
);

    map_t map_q;
    idx_t off_q;

    assign sel = next_set(map_q, off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            off_q <= '0;
        end else if (load) begin
            map_q <= map_in;
            off_q <= '0;
        end else if (adv) begin
            off_q <= idx_inc(sel);
        end
    end

endmodule

// File: rtl/bvadd_rf.sv
module bvadd_rf
    import bvadd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  rf_wr_t                 wr,
    input  idx_t                   raddr,
    output word_t                  rdata,
    output logic [NREG-1:0][XLEN-1:0] all_o
);

    logic [NREG-1:0][XLEN-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr.en && wr.addr != '0) begin
            regs_q[wr.addr] <= wr.data;
        end
    end

    assign all_o = regs_q;
    assign rdata = regs_q[raddr];

endmodule

// File: rtl/bvadd_unit.sv
module bvadd_unit
    import bvadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              map_we,
    input  logic [IW-1:0]     map_addr,
    input  logic [NREG-1:0]   map_wdata,
    output logic [NREG-1:0]   map_rdata,
    input  logic              start,
    input  logic [IW-1:0]     fld_rd,
    input  logic [IW-1:0]     fld_rs1,
    input  logic [IW-1:0]     fld_rs2,
    output logic              busy,
    output logic              done,
    output logic              err,
    input  logic              dbg_we,
    input  logic [IW-1:0]     dbg_addr,
    input  logic [XLEN-1:0]   dbg_wdata,
    output logic [XLEN-1:0]   dbg_rdata
);

    localparam int NOPS = 3;   // destination, source 1, source 2

    state_t  state_q;
    cnt_t    vl_q;
    cnt_t    cnt_q;
    logic    err_q;
    fields_t fld;
    map_t    fmap [NOPS];
    idx_t    sel  [NOPS];
    logic    start_ok;
    logic    any_empty;
    rf_wr_t  rf_wr;
    logic [NREG-1:0][XLEN-1:0] rf_all;
    logic [NREG-1:0][XLEN-1:0] snap_q;

    assign fld = '{rd: fld_rd, rs1: fld_rs1, rs2: fld_rs2};

    bvadd_maps u_maps (
        .clk     (clk),
        .rst     (rst),
        .we      (map_we),
        .addr    (map_addr),
        .wdata   (map_wdata),
        .rdata   (map_rdata),
        .fld     (fld),
        .map_rd  (fmap[0]),
        .map_rs1 (fmap[1]),
        .map_rs2 (fmap[2])
    );

    assign start_ok  = start && (state_q == ST_IDLE);
    assign any_empty = (fmap[0] == '0) || (fmap[1] == '0) || (fmap[2] == '0);

    for (genvar g = 0; g < NOPS; g++) begin : g_iter
        bvadd_iter u_iter (
            .clk    (clk),
            .rst    (rst),
            .load   (start_ok),
            .adv    (state_q == ST_RUN),
            .map_in (fmap[g]),
            .sel    (sel[g])
        );
    end

    always_comb begin
        rf_wr = '0;
        if (state_q == ST_RUN) begin
            rf_wr.en   = 1'b1;
            rf_wr.addr = sel[0];
            rf_wr.data = snap_q[sel[1]] + snap_q[sel[2]];
        end else if (state_q == ST_IDLE && dbg_we) begin
            rf_wr.en   = 1'b1;
            rf_wr.addr = dbg_addr;
            rf_wr.data = dbg_wdata;
        end
    end

    bvadd_rf u_rf (
        .clk   (clk),
        .rst   (rst),
        .wr    (rf_wr),
        .raddr (dbg_addr),
        .rdata (dbg_rdata),
        .all_o (rf_all)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vl_q    <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            snap_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        snap_q  <= rf_all;
                        vl_q    <= popcnt(fmap[0]);
                        cnt_q   <= '0;
                        err_q   <= any_empty;
                        state_q <= any_empty ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + cnt_t'(1);
                    if (cnt_q == vl_q - cnt_t'(1)) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);
    assign err  = (state_q == ST_FIN) && err_q;

endmodule

// File: rtl/bvadd_chk.sv
module bvadd_chk
    import bvadd_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [IW-1:0]   map_addr,
    input logic [NREG-1:0] map_rdata,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic [IW-1:0]   dbg_addr,
    input logic [XLEN-1:0] dbg_rdata
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !done && !err));

    a_r2_map0_fixed: assert property (@(posedge clk) disable iff (rst)
        (map_addr == '0) |-> (map_rdata == map_t'(1)));

    a_r3_x0_zero: assert property (@(posedge clk) disable iff (rst)
        (dbg_addr == '0) |-> (dbg_rdata == '0));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r4_start_takes: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r7_err_needs_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r8_run_continues: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

bind bvadd_unit bvadd_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .map_addr  (map_addr),
    .map_rdata (map_rdata),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .dbg_addr  (dbg_addr),
    .dbg_rdata (dbg_rdata)
);

// File: tb/sim_bvadd_unit.sv
`timescale 1ns/1ps
module sim_bvadd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_we = 1'b0;
    logic [4:0]  map_addr = '0;
    logic [31:0] map_wdata = '0;
    logic [31:0] map_rdata;
    logic        start = 1'b0;
    logic [4:0]  fld_rd = '0, fld_rs1 = '0, fld_rs2 = '0;
    logic        busy, done, err;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] mreg [32];
    logic [31:0] mmap [32];

    always #2.5 clk = ~clk;

    bvadd_unit u0 (
        .clk(clk), .rst(rst),
        .map_we(map_we), .map_addr(map_addr), .map_wdata(map_wdata), .map_rdata(map_rdata),
        .start(start), .fld_rd(fld_rd), .fld_rs1(fld_rs1), .fld_rs2(fld_rs2),
        .busy(busy), .done(done), .err(err),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic map_write(int a, logic [31:0] v);
        @(negedge clk);
        map_we = 1'b1; map_addr = 5'(a); map_wdata = v;
        @(negedge clk);
        map_we = 1'b0;
        if (a != 0) mmap[a] = v;
    endtask

    task automatic map_check(int a, string tag);
        map_addr = 5'(a);
        #0.5;
        check(tag, map_rdata, mmap[a]);
    endtask

    task automatic reg_write(int a, logic [31:0] v);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = 5'(a); dbg_wdata = v;
        @(negedge clk);
        dbg_we = 1'b0;
        if (a != 0) mreg[a] = v;
    endtask

    task automatic regs_check(string tag);
        int bad = 0;
        logic [31:0] a_v = '0, e_v = '0;
        for (int r = 0; r < 32; r++) begin
            dbg_addr = 5'(r);
            #0.2;
            if (dbg_rdata !== mreg[r] && bad == 0) begin
                a_v = dbg_rdata; e_v = mreg[r]; bad = 1;
                $display("  register x%0d differs", r);
            end
        end
        check(tag, a_v, e_v);
    endtask

    function automatic int pick(logic [31:0] m, ref int off);
        for (int k = 0; k < 32; k++) begin
            int j = (off + k) % 32;
            if (m[j]) begin
                off = (j + 1) % 32;
                return j;
            end
        end
        return 0;
    endfunction

    // model: R5 ordering, R6 old-value reads
    task automatic model_add(int rd, int s1, int s2);
        logic [31:0] old [32];
        int o0 = 0, o1 = 0, o2 = 0;
        int vl = $countones(mmap[rd]);
        for (int r = 0; r < 32; r++) old[r] = mreg[r];
        if (mmap[rd] == 0 || mmap[s1] == 0 || mmap[s2] == 0) return;
        for (int i = 0; i < vl; i++) begin
            int d = pick(mmap[rd], o0);
            int a = pick(mmap[s1], o1);
            int b = pick(mmap[s2], o2);
            if (d != 0) mreg[d] = old[a] + old[b];
        end
    endtask

    // poke: same-cycle map write on rd bitmap, then debug write + start while busy (R8, R3)
    task automatic run_add(int rd, int s1, int s2, bit poke, logic [31:0] pmap, string tag);
        int lat;
        int vl = $countones(mmap[rd]);
        bit exp_err = (mmap[rd] == 0 || mmap[s1] == 0 || mmap[s2] == 0);
        int exp_lat = exp_err ? 1 : vl + 1;
        @(negedge clk);
        start = 1'b1; fld_rd = 5'(rd); fld_rs1 = 5'(s1); fld_rs2 = 5'(s2);
        if (poke) begin map_we = 1'b1; map_addr = 5'(rd); map_wdata = pmap; end
        model_add(rd, s1, s2);
        @(negedge clk);
        start = 1'b0; map_we = 1'b0;
        check({tag, " R4 busy after start"}, 32'(busy), 32'd1);
        if (poke) begin
            mmap[rd] = pmap;
            dbg_we = 1'b1; dbg_addr = 5'd10; dbg_wdata = 32'hBAD0BAD0;
            start = 1'b1; fld_rd = 5'd1; fld_rs1 = 5'd1; fld_rs2 = 5'd1;
        end
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            dbg_we = 1'b0; start = 1'b0;
            lat++;
        end
        check({tag, " R4 latency"}, 32'(lat), 32'(exp_lat));
        check({tag, " R7 err flag"}, 32'(err), 32'(exp_err));
        @(negedge clk);
        dbg_we = 1'b0; start = 1'b0;
        check({tag, " R4 done pulse ends"}, 32'(done | busy), 32'd0);
        regs_check({tag, " register file"});
    endtask

    task automatic t_reset();
        for (int n = 0; n < 32; n++) begin mmap[n] = 32'd1 << n; mreg[n] = '0; end
        check("R1 busy", 32'(busy), 0);
        check("R1 done/err", 32'(done | err), 0);
        map_check(0, "R1 map0");
        map_check(7, "R1 map7");
        map_check(31, "R1 map31");
        regs_check("R1 registers zero");
    endtask

    task automatic t_maps();
        map_write(0, 32'h0000_00FF);
        map_check(0, "R2 map0 ignores write");
        map_write(9, 32'hDEAD_BEEF);
        map_check(9, "R2 map9 readback");
        map_write(9, 32'h0000_0200);
        map_check(9, "R2 map9 restore");
    endtask

    task automatic t_regs();
        reg_write(0, 32'h5);
        regs_check("R3 x0 stays zero");
        for (int r = 1; r < 12; r++) reg_write(r, 32'h100 * r + 32'(r));
        regs_check("R3 debug writes");
    endtask

    task automatic t_scalar();
        run_add(3, 1, 2, 0, 0, "R4 scalar add");
    endtask

    task automatic t_default_vec();
        map_write(6, 32'b011111);
        run_add(6, 1, 2, 0, 0, "R4 five-element default sources");
        map_write(6, 32'd1 << 6);
    endtask

    task automatic t_periodic();
        map_write(12, 32'b111110);
        map_write(13, 32'b1101);
        map_write(14, 32'b1000);
        run_add(12, 13, 14, 0, 0, "R5 periodic sources");
    endtask

    task automatic t_snapshot();
        map_write(15, 32'b1100);
        map_write(16, 32'b0100);
        run_add(15, 15, 16, 0, 0, "R6 old values");
    endtask

    task automatic t_empty();
        map_write(17, 32'd0);
        run_add(17, 1, 2, 0, 0, "R7 empty rd");
        run_add(2, 17, 2, 0, 0, "R7 empty rs1");
        map_check(17, "R2 empty readback");
    endtask

    task automatic t_wrap_full();
        map_write(20, 32'hFFFF_FFFF);
        run_add(20, 13, 14, 0, 0, "R5 full-length wrap");
    endtask

    task automatic t_overlap();
        map_write(21, 32'b1111_0000_0000);
        run_add(21, 13, 2, 1, 32'b0010, "R8 same-cycle map write");
        map_check(21, "R8 new map value after run");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_maps();
        t_regs();
        t_scalar();
        t_default_vec();
        t_periodic();
        t_snapshot();
        t_empty();
        t_wrap_full();
        t_overlap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule